// File: doc/BRIEF.md
# WAV Stream Header Formatter

This block turns a stream of unsigned 8-bit mono audio samples into the byte stream of a PCM WAV file, ready for a sector-based storage writer. When a recording begins it sends the canonical 44-byte header. It then forwards samples from a FIFO-style ready/valid input to a ready/valid output and counts each one it forwards.

The total length is not known while the header is being written. The header therefore carries placeholder length fields. When recording stops, the block sends a short patch sequence: eight strobed bytes, each paired with the byte offset in the file where it belongs. The storage writer uses these to rewrite the two length fields in the file's first cluster. The sample rate is a parameter. File-system allocation and the card bus are handled elsewhere.

Top module: `wav_stream_fmt`

## Requirements
- R1: While reset is applied and afterwards, until start_i is seen, out_valid_o, in_ready_o and patch_valid_o are all low.
- R2: When start_i is high in the idle state, the block sends 44 header bytes, one per accepted output handshake. The bytes in order are: "RIFF" (52 49 46 46), 24 00 00 00, "WAVE" (57 41 56 45), "fmt " (66 6D 74 20), 10 00 00 00, 01 00, 01 00, rate (4 bytes), rate (4 bytes), 01 00, 08 00, "data" (64 61 74 61), 00 00 00 00.
- R3: Header bytes 24 to 27 and bytes 28 to 31 each hold SAMPLE_RATE as a 32-bit little-endian value.
- R4: While a header byte is offered and out_ready_i is low, out_data_o and out_valid_o hold their values.
- R5: After the header, out_valid_o follows in_valid_i, out_data_o follows in_data_i, and in_ready_o equals out_ready_i. No sample is consumed while the output is stalled, and samples leave in the order they arrive.
- R6: When stop_i is high while samples stream, the next eight cycles each carry patch_valid_o high. Their offsets are 40, 41, 42 and 43, carrying the sample count little-endian, then 4, 5, 6 and 7, carrying the count plus 36 little-endian. The block is then idle.
- R7: The patched count equals the number of samples accepted since the last start.
- R8: start_i is ignored outside the idle state, and stop_i is ignored outside the streaming state.
- R9: in_ready_o is low except while samples stream. out_valid_o is low while the patch is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a recording (honoured only when idle) |
| stop_i | input | 1 | End a recording (honoured only while streaming) |
| in_data_i | input | 8 | Sample from the input FIFO |
| in_valid_i | input | 1 | Input sample available |
| in_ready_o | output | 1 | Input sample taken this cycle when valid |
| out_data_o | output | 8 | WAV stream byte |
| out_valid_o | output | 1 | Output byte available |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| patch_valid_o | output | 1 | Patch byte strobe |
| patch_offset_o | output | 6 | File byte offset of the patch byte |
| patch_data_o | output | 8 | Patch byte value |

## Verification
The assertions assume that the downstream can take patch bytes on every cycle they are strobed, since the patch path has no ready signal. They also assume that start_i and stop_i are single-cycle pulses. The stimulus follows both rules. It drives start and stop as one-cycle pulses, and it sends stop only after every forwarded sample has drained. It varies the ready pattern, from always ready to random stalls, so that header holds and streaming stalls both occur. It also sends start and stop pulses in states where they must be ignored.

// File: rtl/wav_fmt_pkg.sv
package wav_fmt_pkg;
  localparam int HDR_LEN   = 44;
  localparam int HDR_FIXED = 36;  // header bytes that follow the RIFF size field
  localparam int OFS_W     = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_STREAM,
    ST_PATCH
  } fmt_state_e;
endpackage

// File: rtl/wav_hdr_rom.sv
module wav_hdr_rom
  import wav_fmt_pkg::*;
#(
  parameter int SAMPLE_RATE = 8000
) (
  input  logic [OFS_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam logic [31:0] RATE_W = 32'(SAMPLE_RATE);

  logic [7:0] rate_byte;
  assign rate_byte = RATE_W[8*idx_i[1:0] +: 8];

  always_comb begin
    unique case (idx_i)
      6'd0:  byte_o = 8'h52;
      6'd1:  byte_o = 8'h49;
      6'd2:  byte_o = 8'h46;
      6'd3:  byte_o = 8'h46;
      6'd4:  byte_o = 8'(HDR_FIXED);
      6'd8:  byte_o = 8'h57;
      6'd9:  byte_o = 8'h41;
      6'd10: byte_o = 8'h56;
      6'd11: byte_o = 8'h45;
      6'd12: byte_o = 8'h66;
      6'd13: byte_o = 8'h6D;
      6'd14: byte_o = 8'h74;
      6'd15: byte_o = 8'h20;
      6'd16: byte_o = 8'd16;
      6'd20: byte_o = 8'd1;
      6'd22: byte_o = 8'd1;
      6'd24, 6'd25, 6'd26, 6'd27,
      6'd28, 6'd29, 6'd30, 6'd31: byte_o = rate_byte;  // rate and byte rate
      6'd32: byte_o = 8'd1;
      6'd34: byte_o = 8'd8;
      6'd36: byte_o = 8'h64;
      6'd37: byte_o = 8'h61;
      6'd38: byte_o = 8'h74;
      6'd39: byte_o = 8'h61;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/wav_sample_counter.sv
module wav_sample_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (inc_i) count_o <= count_o + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(count_o)); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0)); // R7
endmodule

// File: rtl/wav_patch_seq.sv
module wav_patch_seq
  import wav_fmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             valid_o,
  output logic [OFS_W-1:0] offset_o,
  output logic [7:0]       data_o,
  output logic             done_o
);
  localparam int DATA_OFS = 40;
  localparam int RIFF_OFS = 4;

  logic [2:0]  idx_q;
  logic [31:0] value;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_q   <= '0;
    end else if (go_i && !valid_o) begin
      valid_o <= 1'b1;
      idx_q   <= '0;
    end else if (valid_o) begin
      valid_o <= !done_o;
      idx_q   <= idx_q + 3'd1;
    end
  end

  // first four bytes: data size; last four: RIFF chunk size
  assign value    = idx_q[2] ? 32'(count_i) + 32'(HDR_FIXED) : 32'(count_i);
  assign offset_o = idx_q[2] ? OFS_W'(RIFF_OFS + 32'(idx_q[1:0]))
                             : OFS_W'(DATA_OFS + 32'(idx_q[1:0]));
  assign data_o   = value[8*idx_q[1:0] +: 8];
  assign done_o   = valid_o && (idx_q == 3'd7);

  AST_PATCH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> valid_o); // R6
  AST_PATCH_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && offset_o == 6'd43) |=> (valid_o && offset_o == 6'd4)); // R6
  AST_PATCH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (offset_o == 6'd40)); // R6
endmodule

// File: rtl/wav_stream_fmt.sv
module wav_stream_fmt
  import wav_fmt_pkg::*;
#(
  parameter int SAMPLE_RATE = 8000,
  parameter int CNT_W       = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             patch_valid_o,
  output logic [OFS_W-1:0] patch_offset_o,
  output logic [7:0]       patch_data_o
);
  localparam logic [OFS_W-1:0] HDR_LAST = OFS_W'(HDR_LEN - 1);

  fmt_state_e       state_q, state_d;
  logic [OFS_W-1:0] hdr_idx_q;
  logic [7:0]       hdr_byte;
  logic [CNT_W-1:0] count;
  logic             begin_rec, take, end_rec, patch_done;

  assign begin_rec = (state_q == ST_IDLE) && start_i;
  assign take      = (state_q == ST_STREAM) && in_valid_i && out_ready_i;
  assign end_rec   = (state_q == ST_STREAM) && stop_i;

  wav_hdr_rom #(.SAMPLE_RATE(SAMPLE_RATE)) u_rom (
    .idx_i (hdr_idx_q),
    .byte_o(hdr_byte)
  );

  wav_sample_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (begin_rec),
    .inc_i  (take),
    .count_o(count)
  );

  wav_patch_seq #(.CNT_W(CNT_W)) u_patch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (end_rec),
    .count_i (count),
    .valid_o (patch_valid_o),
    .offset_o(patch_offset_o),
    .data_o  (patch_data_o),
    .done_o  (patch_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_HDR;
      ST_HDR:    if (out_ready_i && hdr_idx_q == HDR_LAST) state_d = ST_STREAM;
      ST_STREAM: if (stop_i) state_d = ST_PATCH;
      ST_PATCH:  if (patch_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      hdr_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (begin_rec)                              hdr_idx_q <= '0;
      else if (state_q == ST_HDR && out_ready_i)  hdr_idx_q <= hdr_idx_q + 1'b1;
    end
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 8'h00;
    in_ready_o  = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        out_valid_o = 1'b1;
        out_data_o  = hdr_byte;
      end
      ST_STREAM: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        in_ready_o  = out_ready_i;  // never take a sample the sink cannot accept
      end
      default: ;
    endcase
  end

  AST_HDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R4
  AST_NO_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |-> !in_ready_o); // R5
  AST_PATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    patch_valid_o |-> (!out_valid_o && !in_ready_o)); // R9
  AST_PATCH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(patch_valid_o) |-> (state_q == ST_IDLE)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STREAM && start_i && !stop_i) |=> (state_q == ST_STREAM)); // R8
endmodule

// File: tb/tb_wav_stream_fmt.sv
module tb_wav_stream_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int RATE       = 11025;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o;
  logic       out_ready_i = 1'b0;
  logic       patch_valid_o;
  logic [5:0] patch_offset_o;
  logic [7:0] patch_data_o;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  logic [7:0]  exp_q[$];
  logic [13:0] pat_q[$];  // {offset, data}

  wav_stream_fmt #(.SAMPLE_RATE(RATE), .CNT_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .patch_valid_o(patch_valid_o), .patch_offset_o(patch_offset_o),
    .patch_data_o(patch_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr_byte(input int i);
    logic [31:0] r;
    r = RATE;
    case (i)
      0: return "R"; 1: return "I"; 2: return "F"; 3: return "F";
      4: return 8'd36;
      8: return "W"; 9: return "A"; 10: return "V"; 11: return "E";
      12: return "f"; 13: return "m"; 14: return "t"; 15: return " ";
      16: return 8'd16; 20: return 8'd1; 22: return 8'd1;
      24, 28: return r[7:0];
      25, 29: return r[15:8];
      26, 30: return r[23:16];
      27, 31: return r[31:24];
      32: return 8'd1; 34: return 8'd8;
      36: return "d"; 37: return "a"; 38: return "t"; 39: return "a";
      default: return 8'h00;
    endcase
  endfunction

  // ready pattern
  always @(posedge clk) begin
    #1;
    out_ready_i <= (ready_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected byte", out_data_o, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_data_o == e, "R2/R3/R5 stream byte", out_data_o, e);
        end
      end
      if (in_valid_i && !out_ready_i && in_ready_o)
        check(1'b0, "R5 sample taken while stalled", 1, 0);
      if (patch_valid_o) begin
        if (pat_q.size() == 0) check(1'b0, "R6 unexpected patch", patch_offset_o, 0);
        else begin
          logic [13:0] p;
          p = pat_q.pop_front();
          check({patch_offset_o, patch_data_o} == p, "R6/R7 patch byte",
                {patch_offset_o, patch_data_o}, p);
          check(!out_valid_o && !in_ready_o, "R9 quiet during patch",
                {out_valid_o, in_ready_o}, 0);
        end
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic send_sample(input logic [7:0] b);
    exp_q.push_back(b);
    @(posedge clk); #1;
    in_valid_i = 1'b1;
    in_data_i  = b;
    forever begin
      @(negedge clk);
      if (in_ready_o) break;
    end
    @(posedge clk); #1 in_valid_i = 1'b0;
  endtask

  task automatic record(input int n, input bit stop_in_hdr, input bit start_mid);
    logic [31:0] tot;
    pulse(start_i);
    for (int i = 0; i < 44; i++) exp_q.push_back(hdr_byte(i));
    if (stop_in_hdr) pulse(stop_i);  // R8: ignored outside streaming
    for (int i = 0; i < n; i++) begin
      send_sample(8'($urandom));
      if (start_mid && i == n / 2) pulse(start_i);  // R8: ignored while streaming
    end
    wait (exp_q.size() == 0);
    tot = n + 36;
    for (int k = 0; k < 4; k++) pat_q.push_back({6'(40 + k), 8'(n >> (8 * k))});
    for (int k = 0; k < 4; k++) pat_q.push_back({6'(4 + k), tot[8*k +: 8]});
    pulse(stop_i);
    wait (pat_q.size() == 0);
    @(negedge clk);
    check(!patch_valid_o && !out_valid_o && !in_ready_o, "R6/R9 idle after patch",
          {patch_valid_o, out_valid_o, in_ready_o}, 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid_o && !in_ready_o && !patch_valid_o, "R1 in reset",
          {out_valid_o, in_ready_o, patch_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid_o && !in_ready_o && !patch_valid_o, "R1 idle after reset",
          {out_valid_o, in_ready_o, patch_valid_o}, 0);
    // R8: stop while idle does nothing
    pulse(stop_i);
    @(negedge clk);
    check(!patch_valid_o && !out_valid_o, "R8 stop ignored when idle",
          {patch_valid_o, out_valid_o}, 0);
    // R9: input offered while idle is not taken
    in_valid_i = 1'b1;
    @(negedge clk);
    check(!in_ready_o, "R9 no ready when idle", in_ready_o, 0);
    @(posedge clk); #1 in_valid_i = 1'b0;

    ready_mode = 0;
    record(5, 1'b0, 1'b0);   // R2 R3 R5 R7
    ready_mode = 1;
    record(20, 1'b1, 1'b1);  // R4 R5 R8 with stalls
    record(0, 1'b0, 1'b0);   // R7 empty recording
    ready_mode = 0;
    record(300, 1'b0, 1'b1); // R7 count above one byte

    repeat (5) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule